// File: doc/BRIEF.md
# Programmable Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines and presents a single interrupt output to a processor. Each line can be set to edge or level sensing. Requests are latched into a pending register and filtered by a mask register. A rotating-priority resolver then compares the best pending line against the best line already being serviced. The processor acknowledges with a strobe and gets back a vector formed from a programmable base and the chosen line number. It finishes service with one of several end-of-interrupt commands.

Software reaches the controller through a byte-wide port with one address bit. A write on address 0 with bit 4 set starts a three- or four-word initialization sequence. Later words go to address 1 and set the vector base, the auto end-of-interrupt mode and the nested mode. After initialization, address 1 holds the mask. Address 0 takes either mode commands (poll and read-back selection) or service commands (end of interrupt and rotation). A poll read can be used in place of the acknowledge strobe. Only one of write, read and acknowledge is acted on per cycle, in that order of precedence. Read data and the acknowledge vector appear one cycle after the strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An edge-sensed line (trig_level bit 0) sets its pending bit only when the input is high and its stored previous level was low. Holding the input high does not set the bit again after it has been cleared.
- R2: A level-sensed line (trig_level bit 1) has its pending bit follow the input. An acknowledge does not clear it. A low input clears both the pending bit and the stored previous level.
- R3: Priority ranks are counted from a rotation offset R. Line (R + k) mod 8 has rank k, and rank 0 is highest. After reset R is 0.
- R4: int_out is high only when the best unmasked pending line has a strictly better rank than the best in-service line. With nothing in service, any unmasked pending line qualifies. Masked lines never qualify.
- R5: Once nested mode is enabled (bit 4 of the fourth init word), in-service line 2 is left out of the current-service comparison, so a new request on line 2 can interrupt while line 2 is in service.
- R6: A write to address 0 with bit 4 set clears pending, previous-level, mask and in-service state. It also clears the rotation offset, the vector base, all modes and the read select.
- R7: After the first init word, the first address-1 write loads the vector base from bits 7:3. The next address-1 write is the third word. If bit 0 of the first word was set, one more address-1 write is the fourth word (bit 1 = auto end-of-interrupt, bit 4 = nested mode). Any address-1 write after that loads the mask.
- R8: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. If bit 1 is set, bit 0 picks the address-0 read source (1 = in-service, 0 = pending). Address-1 reads return the mask.
- R9: Other address-0 writes decode bits 7:5. The service-clearing commands are:
  - 1 clears the best-ranked in-service bit.
  - 5 does the same and sets R to that line + 1.
  - 3 clears the in-service bit named by bits 2:0.
  - 7 does the same and sets R to that line + 1.
- R10: The remaining address-0 codes in bits 7:5 are:
  - 0 and 4 clear and set rotate-on-auto-end-of-interrupt.
  - 6 sets R to bits 2:0 + 1.
  - 2 changes nothing.
- R11: An acknowledge sets the winning line's in-service bit and clears its pending bit if the line is edge-sensed. It returns vector {base, line}. With no winner it returns {base, 7} and changes nothing.
- R12: With auto end-of-interrupt on, an acknowledge leaves the in-service bit clear. If rotate-on-auto-end-of-interrupt is also set, R becomes line + 1.
- R13: A read while poll is armed returns the winning line number and clears that line's pending and in-service bits. With no winner it returns 7. Either way poll is disarmed.
- R14: After reset, int_out, the read data, the vector and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line sensing: 1 level, 0 edge |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| inta | input | 1 | Interrupt acknowledge strobe |
| ack_vec | output | 8 | Vector, valid the cycle after inta |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
Requests arrive in several patterns:
- A single line, to check that int_out rises and the vector is formed.
- A lower-ranked line while a higher one is in service, to check that it is held off.
- A higher-ranked line that then preempts.
- A masked line, which must stay invisible.
- Two lines under a non-zero rotation, to show that the offset and not the line number decides.

A held-high edge line tells edge sensing apart from level sensing. A level line read back after its acknowledge and after it falls confirms that its pending bit tracks the input. Poll reads with and without a winner, a spurious acknowledge, nested mode on line 2, auto end-of-interrupt with rotation, and the three- and four-word init sequences each exercise a distinct path.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int N_LINES = 8;
    localparam int LINE_W  = $clog2(N_LINES);
    localparam int DATA_W  = 8;
    localparam int BASE_W  = DATA_W - LINE_W;
    localparam int RANK_W  = LINE_W + 1;

    typedef enum logic [1:0] {
        STEP_RUN  = 2'd0,
        STEP_BASE = 2'd1,
        STEP_W3   = 2'd2,
        STEP_W4   = 2'd3
    } init_step_e;

    typedef struct packed {
        logic aeoi;
        logic nested;
        logic rot_aeoi;
        logic rd_isr;
        logic poll;
    } mode_t;

    typedef enum logic [2:0] {
        OP_ROT_AEOI_OFF = 3'd0,
        OP_EOI          = 3'd1,
        OP_NOP          = 3'd2,
        OP_EOI_SPEC     = 3'd3,
        OP_ROT_AEOI_ON  = 3'd4,
        OP_EOI_ROT      = 3'd5,
        OP_SET_PRIO     = 3'd6,
        OP_EOI_SPEC_ROT = 3'd7
    } svc_op_e;

    // Rank of the best set bit in m when ranks start at line off.
    // Returns N_LINES when m is empty.
    function automatic logic [RANK_W-1:0] scan_rank(input logic [N_LINES-1:0] m,
                                                   input logic [LINE_W-1:0] off);
        logic [RANK_W-1:0] r;
        logic [LINE_W-1:0] idx;
        r = RANK_W'(N_LINES);
        for (int p = N_LINES - 1; p >= 0; p--) begin
            idx = LINE_W'(p) + off;
            if (m[idx]) r = RANK_W'(p);
        end
        return r;
    endfunction
endpackage

// File: rtl/irqc_req_unit.sv
module irqc_req_unit
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] trig_level,
    input  logic [N_LINES-1:0] clr_mask,
    output logic [N_LINES-1:0] irr
);
    logic [N_LINES-1:0] irr_q;
    logic [N_LINES-1:0] last_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                irr_q[i]  <= 1'b0;
                last_q[i] <= 1'b0;
            end else begin
                last_q[i] <= irq_in[i];
                if (trig_level[i])
                    irr_q[i] <= irq_in[i] & ~clr_mask[i];
                else
                    irr_q[i] <= (irr_q[i] | (irq_in[i] & ~last_q[i])) & ~clr_mask[i];
            end
        end

        AST_EDGE_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
            (!trig_level[i] && irq_in[i] && !last_q[i] && !clr_mask[i] && !flush)
            |=> irr_q[i]); // R1

        AST_LEVEL_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (trig_level[i] && !irq_in[i]) |=> !irr_q[i]); // R2
    end

    assign irr = irr_q;
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver
    import irqc_pkg::*;
#(
    parameter bit IS_PRIMARY = 1'b1,
    parameter int CASC_LINE  = 2
) (
    input  logic [N_LINES-1:0] irr,
    input  logic [N_LINES-1:0] imr,
    input  logic [N_LINES-1:0] isr,
    input  logic [LINE_W-1:0]  rot,
    input  logic               nested,
    output logic               win_vld,
    output logic [LINE_W-1:0]  win_line,
    output logic               top_vld,
    output logic [LINE_W-1:0]  top_line
);
    logic [N_LINES-1:0] isr_cmp;
    logic [RANK_W-1:0]  req_rank;
    logic [RANK_W-1:0]  cur_rank;
    logic [RANK_W-1:0]  isr_rank;

    always_comb begin
        isr_cmp = isr;
        if (IS_PRIMARY && nested) isr_cmp[CASC_LINE] = 1'b0;
        req_rank = scan_rank(irr & ~imr, rot);
        cur_rank = scan_rank(isr_cmp, rot);
        isr_rank = scan_rank(isr, rot);
        win_vld  = (req_rank != RANK_W'(N_LINES)) && (req_rank < cur_rank);
        win_line = req_rank[LINE_W-1:0] + rot;
        top_vld  = (isr_rank != RANK_W'(N_LINES));
        top_line = isr_rank[LINE_W-1:0] + rot;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter bit IS_PRIMARY = 1'b1,
    parameter int CASC_LINE  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        irq_in,
    input  logic [7:0]        trig_level,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              inta,
    output logic [7:0]        ack_vec,
    output logic              int_out
);
    logic [N_LINES-1:0] irr;
    logic [N_LINES-1:0] isr_q;
    logic [N_LINES-1:0] imr_q;
    logic [LINE_W-1:0]  rot_q;
    logic [BASE_W-1:0]  base_q;
    init_step_e         step_q;
    logic               need4_q;
    mode_t              mode_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  vec_q;

    logic               win_vld, top_vld;
    logic [LINE_W-1:0]  win_line, top_line;
    logic               wr0, wr1, init_go, mode_go, rd_take, ack_take, poll_take;
    logic [N_LINES-1:0] clr_mask;
    logic [LINE_W-1:0]  arg_line;
    svc_op_e            op;

    assign wr0       = bus_wr && !bus_addr;
    assign wr1       = bus_wr && bus_addr;
    assign init_go   = wr0 && bus_wdata[4];
    assign mode_go   = wr0 && !bus_wdata[4] && bus_wdata[3];
    assign rd_take   = bus_rd && !bus_wr;
    assign poll_take = rd_take && mode_q.poll;
    assign ack_take  = inta && !bus_wr && !bus_rd;
    assign arg_line  = bus_wdata[LINE_W-1:0];
    assign op        = svc_op_e'(bus_wdata[7:5]);

    always_comb begin
        clr_mask = '0;
        if (poll_take && win_vld)
            clr_mask[win_line] = 1'b1;
        if (ack_take && win_vld && !trig_level[win_line])
            clr_mask[win_line] = 1'b1;
    end

    irqc_req_unit u_req (
        .clk        (clk),
        .rst        (rst),
        .flush      (init_go),
        .irq_in     (irq_in),
        .trig_level (trig_level),
        .clr_mask   (clr_mask),
        .irr        (irr)
    );

    irqc_resolver #(
        .IS_PRIMARY (IS_PRIMARY),
        .CASC_LINE  (CASC_LINE)
    ) u_res (
        .irr      (irr),
        .imr      (imr_q),
        .isr      (isr_q),
        .rot      (rot_q),
        .nested   (mode_q.nested),
        .win_vld  (win_vld),
        .win_line (win_line),
        .top_vld  (top_vld),
        .top_line (top_line)
    );

    // Control and service state
    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q   <= '0;
            imr_q   <= '0;
            rot_q   <= '0;
            base_q  <= '0;
            step_q  <= STEP_RUN;
            need4_q <= 1'b0;
            mode_q  <= '0;
        end else if (init_go) begin
            isr_q   <= '0;
            imr_q   <= '0;
            rot_q   <= '0;
            base_q  <= '0;
            mode_q  <= '0;
            step_q  <= STEP_BASE;
            need4_q <= bus_wdata[0];
        end else if (mode_go) begin
            if (bus_wdata[2]) mode_q.poll   <= 1'b1;
            if (bus_wdata[1]) mode_q.rd_isr <= bus_wdata[0];
        end else if (wr0) begin
            case (op)
                OP_ROT_AEOI_OFF: mode_q.rot_aeoi <= 1'b0;
                OP_ROT_AEOI_ON:  mode_q.rot_aeoi <= 1'b1;
                OP_EOI: begin
                    if (top_vld) isr_q[top_line] <= 1'b0;
                end
                OP_EOI_ROT: begin
                    if (top_vld) begin
                        isr_q[top_line] <= 1'b0;
                        rot_q           <= top_line + 1'b1;
                    end
                end
                OP_EOI_SPEC: isr_q[arg_line] <= 1'b0;
                OP_SET_PRIO: rot_q <= arg_line + 1'b1;
                OP_EOI_SPEC_ROT: begin
                    isr_q[arg_line] <= 1'b0;
                    rot_q           <= arg_line + 1'b1;
                end
                default: ;
            endcase
        end else if (wr1) begin
            case (step_q)
                STEP_RUN: imr_q <= bus_wdata;
                STEP_BASE: begin
                    base_q <= bus_wdata[DATA_W-1:LINE_W];
                    step_q <= STEP_W3;
                end
                STEP_W3: step_q <= need4_q ? STEP_W4 : STEP_RUN;
                default: begin
                    mode_q.nested <= bus_wdata[4];
                    mode_q.aeoi   <= bus_wdata[1];
                    step_q        <= STEP_RUN;
                end
            endcase
        end else if (rd_take) begin
            if (mode_q.poll) begin
                mode_q.poll <= 1'b0;
                if (win_vld) isr_q[win_line] <= 1'b0;
            end
        end else if (ack_take && win_vld) begin
            if (mode_q.aeoi) begin
                if (mode_q.rot_aeoi) rot_q <= win_line + 1'b1;
            end else begin
                isr_q[win_line] <= 1'b1;
            end
        end
    end

    // Read data and vector registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            vec_q   <= '0;
        end else begin
            if (rd_take) begin
                if (mode_q.poll)
                    rdata_q <= win_vld ? DATA_W'(win_line) : DATA_W'(N_LINES - 1);
                else if (bus_addr)
                    rdata_q <= imr_q;
                else
                    rdata_q <= mode_q.rd_isr ? isr_q : irr;
            end
            if (ack_take)
                vec_q <= {base_q, (win_vld ? win_line : LINE_W'(N_LINES - 1))};
        end
    end

    assign bus_rdata = rdata_q;
    assign ack_vec   = vec_q;
    assign int_out   = win_vld;

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~imr_q) != '0)); // R4

    AST_INIT_CLEARS_STATE: assert property (@(posedge clk) disable iff (rst)
        init_go |=> (isr_q == '0 && imr_q == '0 && rot_q == '0 && step_q == STEP_BASE)); // R6

    AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (ack_take && win_vld && !mode_q.aeoi) |=> isr_q[$past(win_line)]); // R11

    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_take && mode_q.aeoi) |=> (isr_q == $past(isr_q))); // R12

    AST_POLL_DISARMS: assert property (@(posedge clk) disable iff (rst)
        rd_take |=> !mode_q.poll); // R13

    AST_NOP_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (wr0 && !bus_wdata[4] && !bus_wdata[3] && op == OP_NOP)
        |=> (isr_q == $past(isr_q) && rot_q == $past(rot_q))); // R10
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic [7:0] trig_level = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       inta = 1'b0;
    logic [7:0] ack_vec;
    logic       int_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;
    logic       ack_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .trig_level (trig_level),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .inta       (inta),
        .ack_vec    (ack_vec),
        .int_out    (int_out)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected bytes as read data or vectors come out
    always @(posedge clk) begin
        rd_seen  <= bus_rd;
        ack_seen <= inta;
    end

    always @(negedge clk) begin
        if (rd_seen || ack_seen) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL scoreboard underflow actual=%02h expected=none", bus_rdata);
            end else begin
                chk(rd_seen ? bus_rdata : ack_vec, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ack(input logic [7:0] exp, input string tag);
        @(negedge clk);
        inta = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic lines(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic chk_int(input logic exp, input string tag);
        chk({7'b0, int_out}, {7'b0, exp}, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R14 reset state
        chk_int(1'b0, "R14 int_out after reset");
        chk(ack_vec, 8'h00, "R14 vector after reset");
        rd(1'b1, 8'h00, "R14 mask after reset");
        rd(1'b0, 8'h00, "R14 pending after reset");

        // R7 four-word init, base 0x40
        wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h00);

        // R1 edge request, R11 acknowledge
        lines(8'h08);
        chk_int(1'b1, "R1 edge rise raises int");
        rd(1'b0, 8'h08, "R1 pending after edge");
        ack(8'h43, "R11 vector line 3");
        chk_int(1'b0, "R11 int drops after ack");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h08, "R8 read select in-service");

        // R4 lower rank held off, higher preempts
        lines(8'h28);
        chk_int(1'b0, "R4 lower rank blocked");
        lines(8'h2A);
        chk_int(1'b1, "R4 higher rank preempts");
        ack(8'h41, "R11 vector line 1");

        // R9 non-specific EOI
        wr(1'b0, 8'h20);
        rd(1'b0, 8'h08, "R9 EOI clears best in-service");
        chk_int(1'b0, "R4 line 5 still below line 3");
        wr(1'b0, 8'h20);
        chk_int(1'b1, "R9 second EOI releases line 5");
        ack(8'h45, "R11 vector line 5");

        // R1 held lines do not retrigger
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h00, "R1 held edge lines not pending");

        // R4 masking
        lines(8'h00);
        wr(1'b1, 8'h01);
        lines(8'h01);
        chk_int(1'b0, "R4 masked line ignored");
        rd(1'b0, 8'h01, "R4 masked line still pending");
        rd(1'b1, 8'h01, "R8 mask read back");
        wr(1'b1, 8'h00);
        chk_int(1'b1, "R4 unmask raises int");
        ack(8'h40, "R11 vector line 0");
        wr(1'b0, 8'h65);
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h01, "R9 specific EOI line 5");
        wr(1'b0, 8'h60);
        rd(1'b0, 8'h00, "R9 specific EOI line 0");

        // R3 rotation by command 6
        lines(8'h00);
        wr(1'b0, 8'hC3);
        lines(8'h48);
        ack(8'h46, "R3 rotated rank picks line 6");
        chk_int(1'b0, "R3 line 3 lowest after rotate");
        wr(1'b0, 8'hE6);
        chk_int(1'b1, "R9 specific rotate EOI releases");
        ack(8'h43, "R11 vector line 3 after rotate");
        wr(1'b0, 8'hA0);
        rd(1'b0, 8'h00, "R9 rotate EOI clears line 3");
        lines(8'h00);
        lines(8'h24);
        ack(8'h45, "R3 offset 4 favours line 5");
        wr(1'b0, 8'h20);
        ack(8'h42, "R3 line 2 next");
        wr(1'b0, 8'h20);

        // R13 poll
        lines(8'h00);
        lines(8'hC0);
        wr(1'b0, 8'h0C);
        rd(1'b0, 8'h06, "R13 poll returns winner");
        rd(1'b1, 8'h00, "R13 poll disarmed after read");
        chk_int(1'b1, "R13 line 7 still pending");
        wr(1'b0, 8'h0C);
        rd(1'b0, 8'h07, "R13 poll line 7");
        chk_int(1'b0, "R13 poll cleared pending");
        wr(1'b0, 8'h0C);
        rd(1'b0, 8'h07, "R13 poll with no winner");
        ack(8'h47, "R11 spurious ack vector");
        rd(1'b0, 8'h00, "R11 spurious ack leaves in-service");

        // R2 level line
        lines(8'h00);
        trig_level = 8'h10;
        lines(8'h10);
        chk_int(1'b1, "R2 level line raises int");
        ack(8'h44, "R2 level line vector");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h10, "R2 level pending kept after ack");
        chk_int(1'b0, "R4 equal rank not strictly higher");
        lines(8'h00);
        rd(1'b0, 8'h00, "R2 low level clears pending");
        wr(1'b0, 8'h20);
        trig_level = 8'h00;

        // R12 auto EOI with rotation
        wr(1'b0, 8'h11); wr(1'b1, 8'h80); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
        wr(1'b0, 8'h80);
        lines(8'h04);
        ack(8'h82, "R12 auto EOI vector");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h00, "R12 auto EOI leaves in-service clear");
        lines(8'h0A);
        ack(8'h83, "R12 rotated offset 3 picks line 3");
        ack(8'h81, "R12 then line 1");

        // R5 nested mode on line 2
        lines(8'h00);
        wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'h10);
        lines(8'h04);
        ack(8'h02, "R5 vector line 2");
        lines(8'h00);
        lines(8'h04);
        chk_int(1'b1, "R5 line 2 re-interrupts in nested mode");

        // R6/R7 three-word init, mask load afterwards
        lines(8'h00);
        wr(1'b1, 8'h33);
        wr(1'b0, 8'h10); wr(1'b1, 8'h20); wr(1'b1, 8'h00);
        chk_int(1'b0, "R6 int cleared by init");
        rd(1'b1, 8'h00, "R6 mask cleared by init");
        rd(1'b0, 8'h00, "R6 pending cleared by init");
        wr(1'b1, 8'h5A);
        rd(1'b1, 8'h5A, "R7 mask load after third word");
        wr(1'b1, 8'h00);

        // R10 command 2 does nothing
        lines(8'h02);
        ack(8'h21, "R7 base from bits 7:3");
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h40);
        rd(1'b0, 8'h02, "R10 command 2 leaves in-service");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule